// File: doc/BRIEF.md
# Quick Erase Sequencer with Key Reset

This controller runs a destructive erase of a self-encrypting drive. An erase starts from a board-level trigger pin or from a one-cycle host secure-erase request. The first thing it does is write a persistent "erase pending" marker to a non-volatile flag store. It then asks the encryption engine to replace the media key, and that request must complete inside a millisecond budget. Next it asks the media layer to wipe, and finally it asks for a fresh mapping table. Host data access is refused for the whole sequence. The key engine, the media wipe, the mapping rebuild and the firmware purge sit outside the block and are reached through request/done handshakes. The non-volatile store is modelled as a two-bit register with a write strobe, and its read value is returned to the block.

The non-volatile marker survives a power loss. When the block comes out of reset it reads the marker first. If an erase was interrupted, the block restarts the sequence at the key step, and the drive stays locked until the wipe and the rebuild have both finished. A strap input selects a destructive variant. In that variant the sequence ends by purging firmware and mapping data instead of rebuilding, and the drive is left permanently locked.

Top module: `quick_erase_seq`

## Requirements
- R1: The trigger pin (1 = pulled high or shorted, 0 = open) passes through two synchronising flops. An erase starts only after the synchronised level has been high for DEBOUNCE_CYC consecutive clocks. A shorter pulse is ignored. Restarting from the pin needs a new rising level.
- R2: When the block is in the idle or done phase, a one-cycle `host_erase_req` pulse or a debounced pin start begins an erase. In that same cycle the block writes 2'b01 (bit0 = erase pending, bit1 = bricked) to the flag store. `key_reset_req` rises in the following cycle.
- R3: `key_reset_req` stays high until `key_reset_done` is seen. The block then drops it and raises `wipe_req`, which stays high until `wipe_done` is seen.
- R4: `key_timeout_err` goes high if `key_reset_done` has not arrived within KEY_BUDGET_MS milliseconds of entering the key phase, one millisecond being CLKS_PER_MS clocks. The sequence still waits for the done. The error is cleared by reset or by the next erase start.
- R5: `host_acc_ok` equals `host_acc_req` in the idle and done phases. It is 0 in the boot cycle, in the key, wipe and remap phases, and in the bricked phase.
- R6: In normal mode (`brick_mode_en` = 0 when `wipe_done` arrives) the block raises `remap_req` until `remap_done`. Then it writes 2'b00 to the flag store and enters the done phase. The pending bit is never cleared at any other point.
- R7: In brick mode (`brick_mode_en` = 1 when `wipe_done` arrives) the block writes 2'b11 to the flag store and enters the bricked phase. It raises `purge_req` until `purge_done`. It leaves the bricked phase only on reset, and at power-up a set bit1 returns it to the bricked phase with `purge_req` raised again.
- R8: After reset the block reads the flag store. If bit0 = 1 and bit1 = 0, it re-enters the key phase with no new flag write. If both bits are 0, it goes idle.
- R9: `status` is one-hot: bit0 idle (also shown during the single boot cycle), bit1 key reset, bit2 wipe, bit3 remap, bit4 done, bit5 bricked.
- R10: The following have no effect: start requests while an erase or the bricked phase is active, and done strobes that arrive outside their own phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset (power-up) |
| trig_pin | input | 1 | Raw asynchronous erase trigger pin |
| host_erase_req | input | 1 | One-cycle host secure-erase request |
| brick_mode_en | input | 1 | Strap selecting the destructive ending |
| nv_rd_data | input | 2 | Current value of the persistent flag store |
| nv_wr_en | output | 1 | Flag store write strobe |
| nv_wr_data | output | 2 | Flag store write value |
| key_reset_req | output | 1 | Request to replace the media key |
| key_reset_done | input | 1 | Key replacement finished |
| wipe_req | output | 1 | Request for the background media wipe |
| wipe_done | input | 1 | Media wipe finished |
| remap_req | output | 1 | Request to build a new mapping table |
| remap_done | input | 1 | Mapping table built |
| purge_req | output | 1 | Request to remove firmware and mapping data |
| purge_done | input | 1 | Purge finished |
| host_acc_req | input | 1 | Host data access attempt |
| host_acc_ok | output | 1 | Host access granted |
| key_timeout_err | output | 1 | Key replacement exceeded its budget |
| status | output | 6 | One-hot phase indication |

## Verification
The sequence is started by the pin, by the host request and by a power-up with the pending bit already set. Comparing these three tells apart the fresh-start path, which writes the flag before the key request, from the resume path, which does not write it. Pin pulses shorter than the debounce window are set against held levels to separate rejection from acceptance. Seeded random handshake delays and random host access attempts show that access is refused in every locked phase and granted only in idle and done. A key delay beyond the budget, set against short delays, isolates the timeout. Stray done strobes and repeated starts show they have no effect. Brick mode, followed by a reset, shows that the terminal phase persists.

// File: rtl/quick_erase_seq.sv
module quick_erase_seq #(
  parameter int DEBOUNCE_CYC  = 1000,
  parameter int CLKS_PER_MS   = 250000,
  parameter int KEY_BUDGET_MS = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       trig_pin,
  input  logic       host_erase_req,
  input  logic       brick_mode_en,
  input  logic [1:0] nv_rd_data,
  output logic       nv_wr_en,
  output logic [1:0] nv_wr_data,
  output logic       key_reset_req,
  input  logic       key_reset_done,
  output logic       wipe_req,
  input  logic       wipe_done,
  output logic       remap_req,
  input  logic       remap_done,
  output logic       purge_req,
  input  logic       purge_done,
  input  logic       host_acc_req,
  output logic       host_acc_ok,
  output logic       key_timeout_err,
  output logic [5:0] status
);

  localparam int DBW = $clog2(DEBOUNCE_CYC + 1);
  localparam int PSW = (CLKS_PER_MS > 1) ? $clog2(CLKS_PER_MS) : 1;
  localparam int MSW = $clog2(KEY_BUDGET_MS + 1);
  localparam logic [1:0] NV_CLEAR   = 2'b00;
  localparam logic [1:0] NV_PENDING = 2'b01;
  localparam logic [1:0] NV_BRICKED = 2'b11;

  typedef enum logic [2:0] {
    S_BOOT, S_IDLE, S_KEY, S_WIPE, S_REMAP, S_DONE, S_BRICK
  } phase_t;

  phase_t st, st_nx;

  // pin synchroniser and debounce
  logic sync1, sync2;
  logic [DBW-1:0] db_cnt;
  logic pin_fire;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sync1 <= 1'b0;
      sync2 <= 1'b0;
    end else begin
      sync1 <= trig_pin;
      sync2 <= sync1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) db_cnt <= '0;
    else if (!sync2) db_cnt <= '0;
    else if (db_cnt != DBW'(DEBOUNCE_CYC)) db_cnt <= db_cnt + 1'b1;

  assign pin_fire = sync2 && (db_cnt == DBW'(DEBOUNCE_CYC - 1));

  // sequencer
  logic can_start, start;
  assign can_start = (st == S_IDLE) || (st == S_DONE);
  assign start     = can_start && (pin_fire || host_erase_req);

  always_comb begin
    st_nx      = st;
    nv_wr_en   = 1'b0;
    nv_wr_data = NV_CLEAR;
    case (st)
      S_BOOT:
        if (nv_rd_data[1])      st_nx = S_BRICK;
        else if (nv_rd_data[0]) st_nx = S_KEY;
        else                    st_nx = S_IDLE;
      S_IDLE, S_DONE:
        if (start) begin
          st_nx      = S_KEY;
          nv_wr_en   = 1'b1;
          nv_wr_data = NV_PENDING;
        end
      S_KEY:
        if (key_reset_done) st_nx = S_WIPE;
      S_WIPE:
        if (wipe_done) begin
          if (brick_mode_en) begin
            st_nx      = S_BRICK;
            nv_wr_en   = 1'b1;
            nv_wr_data = NV_BRICKED;
          end else begin
            st_nx = S_REMAP;
          end
        end
      S_REMAP:
        if (remap_done) begin
          st_nx      = S_DONE;
          nv_wr_en   = 1'b1;
          nv_wr_data = NV_CLEAR;
        end
      default: st_nx = st;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) st <= S_BOOT;
    else        st <= st_nx;

  // purge handshake bookkeeping inside the bricked phase
  logic purge_seen;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                        purge_seen <= 1'b0;
    else if (st != S_BRICK)            purge_seen <= 1'b0;
    else if (purge_done)               purge_seen <= 1'b1;

  // key budget timer
  logic [PSW-1:0] pre_cnt;
  logic [MSW-1:0] ms_cnt;
  logic           err_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pre_cnt <= '0;
      ms_cnt  <= '0;
    end else if (st != S_KEY) begin
      pre_cnt <= '0;
      ms_cnt  <= '0;
    end else if (pre_cnt == PSW'(CLKS_PER_MS - 1)) begin
      pre_cnt <= '0;
      if (ms_cnt != MSW'(KEY_BUDGET_MS)) ms_cnt <= ms_cnt + 1'b1;
    end else begin
      pre_cnt <= pre_cnt + 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                                           err_q <= 1'b0;
    else if (start)                                       err_q <= 1'b0;
    else if (st == S_KEY && ms_cnt == MSW'(KEY_BUDGET_MS)) err_q <= 1'b1;

  // outputs
  logic locked;
  assign locked          = !can_start;
  assign key_reset_req   = (st == S_KEY);
  assign wipe_req        = (st == S_WIPE);
  assign remap_req       = (st == S_REMAP);
  assign purge_req       = (st == S_BRICK) && !purge_seen;
  assign host_acc_ok     = host_acc_req && !locked;
  assign key_timeout_err = err_q;

  always_comb
    case (st)
      S_KEY:   status = 6'b000010;
      S_WIPE:  status = 6'b000100;
      S_REMAP: status = 6'b001000;
      S_DONE:  status = 6'b010000;
      S_BRICK: status = 6'b100000;
      default: status = 6'b000001;
    endcase

  // assertions
  a_r2_flag_before_key: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(key_reset_req) |-> nv_rd_data[0]);

  a_r5_locked_no_access: assert property (@(posedge clk) disable iff (!rst_n)
    (key_reset_req || wipe_req || remap_req || status[5]) |-> !host_acc_ok);

  a_r6_clear_after_remap: assert property (@(posedge clk) disable iff (!rst_n)
    (nv_wr_en && nv_wr_data == NV_CLEAR) |-> remap_done);

  a_r4_timeout_in_key: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(key_timeout_err) |-> $past(key_reset_req));

  a_r7_brick_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    status[5] |=> status[5]);

  a_r9_onehot_status: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(status));

  a_r3_single_request: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({key_reset_req, wipe_req, remap_req, purge_req}));

endmodule

// File: tb/quick_erase_seq_tb_top.sv
module quick_erase_seq_tb_top;
  localparam int DEB = 8;
  localparam int CPM = 4;
  localparam int BUD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic trig_pin = 0, host_erase_req = 0, brick_mode_en = 0;
  logic [1:0] nv_q = 2'b00;
  logic nv_wr_en; logic [1:0] nv_wr_data;
  logic key_reset_req, key_reset_done = 0, wipe_req, wipe_done = 0;
  logic remap_req, remap_done = 0, purge_req, purge_done = 0;
  logic host_acc_req = 0, host_acc_ok, key_timeout_err;
  logic [5:0] status;
  int vectors = 0, fails = 0;

  always #2 clk = ~clk;

  always @(posedge clk) if (nv_wr_en) nv_q <= nv_wr_data;

  quick_erase_seq #(.DEBOUNCE_CYC(DEB), .CLKS_PER_MS(CPM), .KEY_BUDGET_MS(BUD)) dut_i (
    .clk(clk), .rst_n(rst_n), .trig_pin(trig_pin), .host_erase_req(host_erase_req),
    .brick_mode_en(brick_mode_en), .nv_rd_data(nv_q), .nv_wr_en(nv_wr_en),
    .nv_wr_data(nv_wr_data), .key_reset_req(key_reset_req), .key_reset_done(key_reset_done),
    .wipe_req(wipe_req), .wipe_done(wipe_done), .remap_req(remap_req), .remap_done(remap_done),
    .purge_req(purge_req), .purge_done(purge_done), .host_acc_req(host_acc_req),
    .host_acc_ok(host_acc_ok), .key_timeout_err(key_timeout_err), .status(status));

  function automatic logic [5:0] ph(int idx);
    return 6'b1 << idx;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 0; tick(3); rst_n = 1; tick(1);
  endtask

  // random host attempts each cycle, checked against the known lock state
  task automatic hold_locked(int n, bit locked, string req);
    for (int i = 0; i < n; i++) begin
      host_acc_req = $urandom_range(0, 1);
      #0.5;
      chk(req, host_acc_ok, host_acc_req && !locked);
      tick(1);
    end
    host_acc_req = 0;
  endtask

  task automatic wait_key(int lim);
    for (int i = 0; i < lim && !key_reset_req; i++) tick(1);
  endtask

  task automatic pulse(ref logic s);
    s = 1; tick(1); s = 0;
  endtask

  task automatic finish_normal(int dk, int dw, int dr);
    hold_locked(dk, 1, "R5 key");
    chk("R3 key req held", key_reset_req, 1);
    pulse(key_reset_done);
    chk("R3 wipe phase", status, ph(2));
    chk("R3 wipe_req", {key_reset_req, wipe_req}, 2'b01);
    chk("R4 no timeout on short key", key_timeout_err, 0);
    hold_locked(dw, 1, "R5 wipe");
    pulse(wipe_done);
    chk("R6 remap phase", status, ph(3));
    chk("R6 flag still pending", nv_q, 2'b01);
    hold_locked(dr, 1, "R5 remap");
    pulse(remap_done);
    chk("R6 done phase", status, ph(4));
    chk("R6 flag cleared", nv_q, 2'b00);
    hold_locked(3, 0, "R5 done open");
  endtask

  initial begin
    int seed = 32'h5eed1;
    void'($urandom(seed));
    tick(2);
    rst_n = 1; tick(1);
    // reset state
    chk("R9 idle after reset", status, ph(0));
    chk("R3 no requests at reset", {key_reset_req, wipe_req, remap_req, purge_req}, 0);
    hold_locked(4, 0, "R5 idle open");

    // short pin glitch ignored
    trig_pin = 1; tick(DEB - 2); trig_pin = 0; tick(20);
    chk("R1 glitch ignored", status, ph(0));
    chk("R1 no flag write", nv_q, 2'b00);

    // held pin starts
    trig_pin = 1; tick(3);
    chk("R1 not before debounce", status, ph(0));
    wait_key(20);
    chk("R1 pin start", status, ph(1));
    chk("R2 flag written before key", nv_q, 2'b01);
    trig_pin = 0;
    finish_normal(5, 7, 3);

    // stray done strobes in done phase
    pulse(key_reset_done); pulse(wipe_done); pulse(remap_done); pulse(purge_done);
    tick(1);
    chk("R10 stray done ignored", status, ph(4));
    chk("R10 flag untouched", nv_q, 2'b00);

    // host start, repeated starts, timeout, power loss in wipe
    pulse(host_erase_req);
    chk("R2 host start", status, ph(1));
    chk("R2 host flag", nv_q, 2'b01);
    pulse(host_erase_req); pulse(wipe_done); pulse(remap_done);
    chk("R10 ignored in key", status, ph(1));
    tick(25);
    chk("R4 not yet timed out", key_timeout_err, 0);
    tick(20);
    chk("R4 timeout raised", key_timeout_err, 1);
    chk("R4 still waiting", key_reset_req, 1);
    pulse(key_reset_done);
    chk("R4 continues to wipe", status, ph(2));
    chk("R4 error sticky", key_timeout_err, 1);
    tick(3);
    rst_n = 0; tick(2); rst_n = 1;
    #0.5;
    chk("R5 boot cycle locked", host_acc_ok, 0);
    tick(1);
    chk("R8 resume into key", status, ph(1));
    chk("R8 flag kept", nv_q, 2'b01);
    chk("R4 err cleared by reset", key_timeout_err, 0);
    finish_normal(4, 4, 4);

    // random rounds
    for (int r = 0; r < 20; r++) begin
      if ($urandom_range(0, 1)) pulse(host_erase_req);
      else begin trig_pin = 1; wait_key(DEB + 6); trig_pin = 0; end
      chk("R2 random start", status, ph(1));
      finish_normal($urandom_range(0, 20), $urandom_range(0, 30), $urandom_range(0, 15));
    end

    // brick mode
    brick_mode_en = 1;
    pulse(host_erase_req);
    pulse(key_reset_done);
    pulse(wipe_done);
    chk("R7 bricked phase", status, ph(5));
    chk("R7 brick flag", nv_q, 2'b11);
    chk("R7 purge requested", purge_req, 1);
    hold_locked(5, 1, "R5 bricked");
    pulse(purge_done);
    chk("R7 purge dropped", purge_req, 0);
    pulse(host_erase_req); tick(2);
    chk("R10 start ignored bricked", status, ph(5));
    brick_mode_en = 0;
    do_reset();
    chk("R7 bricked after power-up", status, ph(5));
    chk("R7 purge re-requested", purge_req, 1);
    nv_q = 2'b00;
    do_reset();
    chk("R8 clean boot idle", status, ph(0));
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule